// File: doc/BRIEF.md
# Shared Work Queue Submission Port

This block is the device end of a work queue that many software submitters reach through one shared submission address. A submitter presents a whole work descriptor in a single cycle: an operation code, the virtual addresses of its arguments, the virtual address where a completion record should go, and the 20-bit address-space ID that identifies the submitting process. Submitters are told apart only by that ID. There is no per-submitter port and no back-pressure on the submit side.

Each submission is non-posted. The port answers every strobe with a status, either accept or retry. A descriptor is accepted only when the queue is enabled and a slot is free, or will be freed by a drain in the same cycle. An accepted descriptor is stored whole, together with its address-space ID, in an internal queue whose depth is a parameter. A retried descriptor leaves no trace. The queue tracks its own occupancy, so submitters never see it.

A downstream execution engine removes descriptors in arrival order through a valid/ready interface.

Top module: `swq_port`

## Requirements
- R1: While reset is asserted and right after its release, `rsp_valid` and `drain_valid` are 0.
- R2: Every cycle in which `sub_valid` is 1 produces exactly one response: `rsp_valid` is 1 in the following cycle. `rsp_valid` is 0 after any cycle in which `sub_valid` was 0.
- R3: With `q_enable` at 1 and fewer than DEPTH entries stored, a submission is answered with `rsp_accept` = 1. Its operation code, argument addresses, completion address and address-space ID are all stored unchanged as one entry.
- R4: With DEPTH entries stored and no drain in the same cycle, a submission is answered with `rsp_accept` = 0 (retry) and is not stored. Occupancy never exceeds DEPTH.
- R5: With DEPTH entries stored and a drain handshake in the same cycle, a submission is accepted and stored.
- R6: While `q_enable` is 0, every submission is answered with `rsp_accept` = 0 and is not stored. Draining still works.
- R7: Entries leave in the order they were accepted. A drain happens on a cycle where `drain_valid` and `drain_ready` are both 1. While `drain_valid` is 1 and `drain_ready` is 0, the output fields hold steady.
- R8: `drain_valid` is 1 exactly when at least one entry is stored. A submission accepted at one clock edge is visible at the drain interface after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_enable | input | 1 | Queue enable; while 0 all submissions are retried |
| sub_valid | input | 1 | Submit strobe, one descriptor per cycle |
| sub_op | input | OP_W | Operation code |
| sub_args | input | NARG*VA_W | Argument virtual addresses, packed |
| sub_cmpl | input | VA_W | Completion record virtual address |
| sub_asid | input | ID_W | Submitter address-space ID |
| rsp_valid | output | 1 | Status present for the previous cycle's submission |
| rsp_accept | output | 1 | 1 = accepted, 0 = retry |
| drain_valid | output | 1 | Head entry available |
| drain_ready | input | 1 | Engine takes head entry |
| drain_op | output | OP_W | Head operation code |
| drain_args | output | NARG*VA_W | Head argument addresses |
| drain_cmpl | output | VA_W | Head completion address |
| drain_asid | output | ID_W | Head address-space ID |

## Verification
The status for a submit strobe is due exactly one clock edge after the strobe. A stored entry, or the removal of the head after a drain handshake, shows at the drain outputs right after the edge on which it happened, because those outputs are read combinationally from the stored state. The bench drives inputs on the falling edge and advances a queue model by the same edge's decisions. On the next falling edge it compares the status against the decision recorded one edge earlier and the drain outputs against the model's head. This keeps every comparison exactly one edge behind its stimulus.

// File: rtl/swq_port.sv
module swq_port #(
  parameter int DEPTH = 16,
  parameter int OP_W  = 8,
  parameter int VA_W  = 48,
  parameter int NARG  = 2,
  parameter int ID_W  = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 q_enable,
  input  logic                 sub_valid,
  input  logic [OP_W-1:0]      sub_op,
  input  logic [NARG*VA_W-1:0] sub_args,
  input  logic [VA_W-1:0]      sub_cmpl,
  input  logic [ID_W-1:0]      sub_asid,
  output logic                 rsp_valid,
  output logic                 rsp_accept,
  output logic                 drain_valid,
  input  logic                 drain_ready,
  output logic [OP_W-1:0]      drain_op,
  output logic [NARG*VA_W-1:0] drain_args,
  output logic [VA_W-1:0]      drain_cmpl,
  output logic [ID_W-1:0]      drain_asid
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int DW = OP_W + NARG*VA_W + VA_W + ID_W;

  logic [DW-1:0] slots [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] fill;

  wire pop  = drain_valid && drain_ready;
  wire full = (fill == CW'(DEPTH));
  wire take = sub_valid && q_enable && (!full || pop);

  assign drain_valid = (fill != '0);
  assign {drain_op, drain_args, drain_cmpl, drain_asid} = slots[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      fill       <= '0;
      rsp_valid  <= 1'b0;
      rsp_accept <= 1'b0;
    end else begin
      rsp_valid  <= sub_valid;
      rsp_accept <= take;
      if (take) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      fill <= fill + CW'(take) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (take) slots[wr_ptr] <= {sub_op, sub_args, sub_cmpl, sub_asid};
  end

  a_r2_status_next: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid |=> rsp_valid);
  a_r2_no_stray: assert property (@(posedge clk) disable iff (!rst_n)
    !sub_valid |=> !rsp_valid);
  a_r6_disabled_retry: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_valid && !q_enable) |=> !rsp_accept);
  a_r4_full_retry: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_valid && full && !drain_ready) |=> (!rsp_accept && full));
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_valid && !drain_ready) |=> (drain_valid && $stable(drain_asid) && $stable(drain_op)));
  a_r8_fill_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> drain_valid);
endmodule

// File: tb/tb_swq_port.sv
module tb_swq_port;
  localparam int DEPTH = 16, OP_W = 8, VA_W = 48, NARG = 2, ID_W = 20;
  localparam int DW = OP_W + NARG*VA_W + VA_W + ID_W;

  logic clk = 0, rst_n = 0, q_enable = 0, sub_valid = 0, drain_ready = 0;
  logic [OP_W-1:0] sub_op = '0;
  logic [NARG*VA_W-1:0] sub_args = '0;
  logic [VA_W-1:0] sub_cmpl = '0;
  logic [ID_W-1:0] sub_asid = '0;
  logic rsp_valid, rsp_accept, drain_valid;
  logic [OP_W-1:0] drain_op;
  logic [NARG*VA_W-1:0] drain_args;
  logic [VA_W-1:0] drain_cmpl;
  logic [ID_W-1:0] drain_asid;

  swq_port #(.DEPTH(DEPTH), .OP_W(OP_W), .VA_W(VA_W), .NARG(NARG), .ID_W(ID_W)) dut (
    .clk(clk), .rst_n(rst_n), .q_enable(q_enable), .sub_valid(sub_valid),
    .sub_op(sub_op), .sub_args(sub_args), .sub_cmpl(sub_cmpl), .sub_asid(sub_asid),
    .rsp_valid(rsp_valid), .rsp_accept(rsp_accept), .drain_valid(drain_valid),
    .drain_ready(drain_ready), .drain_op(drain_op), .drain_args(drain_args),
    .drain_cmpl(drain_cmpl), .drain_asid(drain_asid));

  always #10 clk = ~clk;

  int total = 0, bad = 0, serial = 0;
  bit finished = 0;
  logic [DW-1:0] model [$];
  bit exp_rv = 0, exp_ok = 0;
  string ok_tag = "R3";
  logic [31:0] lfsr = 32'h1234_5678;

  task automatic check(input bit cond, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_outputs();
    check(rsp_valid == exp_rv, "R2", DW'(rsp_valid), DW'(exp_rv));
    if (exp_rv) check(rsp_accept == exp_ok, ok_tag, DW'(rsp_accept), DW'(exp_ok));
    check(drain_valid == (model.size() != 0), "R8", DW'(drain_valid), DW'(model.size() != 0));
    if (model.size() != 0)
      check({drain_op, drain_args, drain_cmpl, drain_asid} == model[0], "R7",
            {drain_op, drain_args, drain_cmpl, drain_asid}, model[0]);
  endtask

  task automatic cycle(input bit v, input bit en, input bit rdy);
    bit pop, acc;
    check_outputs();
    serial++;
    sub_valid = v; q_enable = en; drain_ready = rdy;
    sub_op   = OP_W'(serial * 7);
    sub_args = {VA_W'(serial * 48'h1_0001), VA_W'(48'hA000_0000 + serial)};
    sub_cmpl = VA_W'(48'hC000_0000 ^ (serial << 4));
    sub_asid = ID_W'(lfsr[19:0] ^ serial);
    pop = (model.size() != 0) && rdy;
    acc = v && en && ((model.size() < DEPTH) || pop);
    if (!en) ok_tag = "R6";
    else if (model.size() == DEPTH) ok_tag = pop ? "R5" : "R4";
    else ok_tag = "R3";
    exp_rv = v; exp_ok = acc;
    if (pop) void'(model.pop_front());
    if (acc) model.push_back({sub_op, sub_args, sub_cmpl, sub_asid});
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check(rsp_valid == 0 && drain_valid == 0, "R1", DW'({rsp_valid, drain_valid}), '0);
    rst_n = 1;
    @(negedge clk);
    check(rsp_valid == 0 && drain_valid == 0, "R1", DW'({rsp_valid, drain_valid}), '0);
    for (int i = 0; i < 6; i++) cycle(1, 1, 0);
    for (int i = 0; i < 3; i++) cycle(0, 1, 1);
    for (int i = 0; i < 20; i++) cycle(1, 1, 0);
    for (int i = 0; i < 3; i++) cycle(1, 1, 1);
    for (int i = 0; i < 4; i++) cycle(1, 0, 0);
    for (int i = 0; i < 3; i++) cycle(1, 0, 1);
    for (int i = 0; i < 20; i++) cycle(0, 1, 1);
    for (int i = 0; i < 400; i++) cycle(lfsr[3], lfsr[9:7] != 0, lfsr[14] | lfsr[5]);
    for (int i = 0; i < 20; i++) cycle(0, 1, 1);
    check_outputs();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule